// File: doc/BRIEF.md
# GPIO Interrupt Routing Multiplexer

This block gathers the interrupt requests of three 32-line GPIO banks and places them on 41 global interrupt lines. Those lines feed a platform interrupt controller. Bank 2 has no direct lines of its own. Instead, it shares the first 32 global slots with banks 0 and 1. A 32-bit select word picks the source of each shared slot, one bit per slot.

- Slots 0 to 13 take a bank-0 line or the bank-2 line with the same number.
- Slots 14 to 31 take a bank-1 line or the bank-2 line with the same number.
- Slots 32 to 37 always carry bank-1 lines 18 to 23.

A line can be left without a direct slot, either because no slot exists for it or because its slot is given to the other bank. Such a line is merged into an OR output for its own bank. These OR outputs are lines 38, 39 and 40.

Software loads the select word through a write-enable and data port, and it can read the word back. All 41 outputs come from registers. A change of the select word therefore appears as one clean switch, one cycle later. The controller source number of global line 0 is a parameter, and it is presented on a constant output.

Top module: `gpio_irq_router`

## Requirements
- R1: During and just after reset, the select word reads 0 and all 41 global lines are 0.
- R2: For n in 0..13, global line n carries bank-0 bit n when select bit n is 0, and bank-2 bit n when select bit n is 1.
- R3: For n in 14..31, global line n carries bank-1 bit n-14 when select bit n is 0, and bank-2 bit n when select bit n is 1.
- R4: Global lines 32..37 always carry bank-1 bits 18..23.
- R5: Global line 38 is the OR of bank-0 bits 14..31 and of each bank-0 bit n (n in 0..13) whose select bit n is 1.
- R6: Global line 39 is the OR of bank-1 bits 24..31 and of each bank-1 bit k (k in 0..17) whose select bit 14+k is 1. Bank-1 bits 18..23 never reach line 39.
- R7: Global line 40 is the OR of each bank-2 bit k whose select bit k is 0.
- R8: When the write enable is high at a clock edge, the select word takes the write data, and the read-back port shows it after that edge. When the write enable is low, the word does not change, whatever the write data holds.
- R9: Each global line changes exactly one clock edge after the inputs and select word that produce it. Between edges it holds its value.
- R10: The base output reports the controller source number of global line 0, which is 13 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Select word write enable |
| cfg_wdata | input | 32 | Select word write data |
| cfg_rdata | output | 32 | Current select word |
| bank0_irq | input | 32 | Bank-0 interrupt requests |
| bank1_irq | input | 32 | Bank-1 interrupt requests |
| bank2_irq | input | 32 | Bank-2 interrupt requests |
| gout | output | 41 | Global interrupt lines, bit n is line n |
| src_base | output | 8 | Controller source number of line 0 |

## Verification
The bench builds the block with its default split: 14 bank-0 slots, 18 shared bank-1 slots, 6 fixed bank-1 slots, 32 lines per bank and a base of 13. With this split the shared slots cover all 32 bank-2 lines. That brings within reach the boundary lines 13/14, 31/32 and 37/38, bank-0 line 14 (which never has a slot) and bank-1 line 24 (which is always merged).

Random request vectors and random select words, from a fixed seed, exercise every mix of direct and merged lines. Directed cases cover select words of all zeros, all ones and alternating bits.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int W        = 32,
  parameter int N0       = 14,
  parameter int N1S      = 18,
  parameter int N1F      = 6,
  parameter int IRQ_BASE = 13,
  parameter int BASE_W   = 8,
  localparam int NSEL    = N0 + N1S,
  localparam int NOUT    = NSEL + N1F + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [W-1:0]      cfg_wdata,
  output logic [W-1:0]      cfg_rdata,
  input  logic [W-1:0]      bank0_irq,
  input  logic [W-1:0]      bank1_irq,
  input  logic [W-1:0]      bank2_irq,
  output logic [NOUT-1:0]   gout,
  output logic [BASE_W-1:0] src_base
);
  localparam int AGG0 = NSEL + N1F;

  logic [W-1:0]    sel;
  logic [W-1:0]    dir0, dir1, dir2;
  logic [NOUT-1:0] nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel <= '0;
    else if (cfg_we) sel <= cfg_wdata;

  assign cfg_rdata = sel;
  assign src_base  = BASE_W'(IRQ_BASE);

  for (genvar i = 0; i < W; i++) begin : g_dir
    if (i < N0) begin : g_d0
      assign dir0[i] = ~sel[i];
    end else begin : g_n0
      assign dir0[i] = 1'b0;
    end
    if (i < N1S) begin : g_d1s
      assign dir1[i] = ~sel[N0+i];
    end else if (i < N1S + N1F) begin : g_d1f
      assign dir1[i] = 1'b1;
    end else begin : g_n1
      assign dir1[i] = 1'b0;
    end
    if (i < NSEL) begin : g_d2
      assign dir2[i] = sel[i];
    end else begin : g_n2
      assign dir2[i] = 1'b0;
    end
  end

  for (genvar n = 0; n < NSEL; n++) begin : g_slot
    if (n < N0) begin : g_lo
      assign nxt[n] = sel[n] ? bank2_irq[n] : bank0_irq[n];
    end else begin : g_hi
      assign nxt[n] = sel[n] ? bank2_irq[n] : bank1_irq[n-N0];
    end
  end

  for (genvar j = 0; j < N1F; j++) begin : g_fix
    assign nxt[NSEL+j] = bank1_irq[N1S+j];
  end

  assign nxt[AGG0]   = |(bank0_irq & ~dir0);
  assign nxt[AGG0+1] = |(bank1_irq & ~dir1);
  assign nxt[AGG0+2] = |(bank2_irq & ~dir2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gout <= '0;
    else        gout <= nxt;
endmodule

module gpio_irq_router_chk #(
  parameter int W   = 32,
  parameter int N0  = 14,
  parameter int N1S = 18,
  parameter int N1F = 6,
  localparam int NSEL = N0 + N1S,
  localparam int NOUT = NSEL + N1F + 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [W-1:0]    cfg_wdata,
  input logic [W-1:0]    cfg_rdata,
  input logic [W-1:0]    bank0_irq,
  input logic [W-1:0]    bank1_irq,
  input logic [W-1:0]    bank2_irq,
  input logic [NOUT-1:0] gout
);
  localparam int AGG0 = NSEL + N1F;
  logic armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_slot_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> gout[N0-1:0] ==
      (($past(cfg_rdata[N0-1:0]) & $past(bank2_irq[N0-1:0])) |
       (~$past(cfg_rdata[N0-1:0]) & $past(bank0_irq[N0-1:0]))));

  p_slot_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> gout[NSEL-1:N0] ==
      (($past(cfg_rdata[NSEL-1:N0]) & $past(bank2_irq[NSEL-1:N0])) |
       (~$past(cfg_rdata[NSEL-1:N0]) & $past(bank1_irq[N1S-1:0]))));

  p_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> gout[AGG0-1:NSEL] == $past(bank1_irq[N1S+N1F-1:N1S]));

  p_agg0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> gout[AGG0] ==
      ((|$past(bank0_irq[W-1:N0])) |
       (|($past(bank0_irq[N0-1:0]) & $past(cfg_rdata[N0-1:0])))));

  p_agg1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> gout[AGG0+1] ==
      ((|$past(bank1_irq[W-1:N1S+N1F])) |
       (|($past(bank1_irq[N1S-1:0]) & $past(cfg_rdata[NSEL-1:N0])))));

  p_agg2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> gout[AGG0+2] ==
      (|($past(bank2_irq[NSEL-1:0]) & ~$past(cfg_rdata[NSEL-1:0]))));

  p_cfg_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cfg_we)) |-> cfg_rdata == $past(cfg_wdata));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(cfg_we)) |-> $stable(cfg_rdata));
endmodule

bind gpio_irq_router gpio_irq_router_chk #(.W(W), .N0(N0), .N1S(N1S), .N1F(N1F)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .bank0_irq(bank0_irq), .bank1_irq(bank1_irq),
  .bank2_irq(bank2_irq), .gout(gout)
);

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] b0 = '0, b1 = '0, b2 = '0;
  logic [40:0] gout;
  logic [7:0]  src_base;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [31:0] cur_cfg = '0;
  logic [40:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  gpio_irq_router u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bank0_irq(b0), .bank1_irq(b1), .bank2_irq(b2),
    .gout(gout), .src_base(src_base)
  );

  function automatic logic [40:0] model(logic [31:0] c, logic [31:0] x0,
                                        logic [31:0] x1, logic [31:0] x2);
    logic [40:0] e;
    for (int n = 0; n < 14; n++) e[n] = c[n] ? x2[n] : x0[n];
    for (int n = 14; n < 32; n++) e[n] = c[n] ? x2[n] : x1[n-14];
    for (int n = 32; n < 38; n++) e[n] = x1[n-14];
    e[38] = (|x0[31:14]) | (|(x0[13:0] & c[13:0]));
    e[39] = (|x1[31:24]) | (|(x1[17:0] & c[31:14]));
    e[40] = |(x2 & ~c);
    return e;
  endfunction

  task automatic chk(string tag, logic [40:0] act, logic [40:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(logic [40:0] e);
    chk("R2 slots 0..13",  {27'd0, gout[13:0]},  {27'd0, e[13:0]});
    chk("R3 slots 14..31", {23'd0, gout[31:14]}, {23'd0, e[31:14]});
    chk("R4 fixed 32..37", {35'd0, gout[37:32]}, {35'd0, e[37:32]});
    chk("R5 bank0 OR",     {40'd0, gout[38]},    {40'd0, e[38]});
    chk("R6 bank1 OR",     {40'd0, gout[39]},    {40'd0, e[39]});
    chk("R7 bank2 OR",     {40'd0, gout[40]},    {40'd0, e[40]});
  endtask

  task automatic drive(logic [31:0] x0, logic [31:0] x1, logic [31:0] x2);
    logic [40:0] e;
    @(negedge clk);
    b0 = x0; b1 = x1; b2 = x2;
    #1;
    chk("R9 hold before edge", gout, prev_exp);
    e = model(cur_cfg, x0, x1, x2);
    @(posedge clk); #1;
    compare(e);
    prev_exp = e;
  endtask

  task automatic wcfg(logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = ~v;
    chk("R8 write readback", {9'd0, cfg_rdata}, {9'd0, v});
    cur_cfg = v;
    @(negedge clk);
    chk("R8 no write when disabled", {9'd0, cfg_rdata}, {9'd0, v});
    prev_exp = model(cur_cfg, b0, b1, b2);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    b0 = 32'hFFFF_FFFF; b1 = 32'hFFFF_FFFF; b2 = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", gout, '0);
    chk("R1 reset select", {9'd0, cfg_rdata}, '0);
    chk("R10 base", {33'd0, src_base}, 41'd13);
    @(negedge clk);
    rst_n = 1'b1;
    b0 = '0; b1 = '0; b2 = '0;
    @(posedge clk); #1;
    chk("R1 after reset", gout, '0);
    prev_exp = '0;

    drive(32'hFFFF_FFFF, '0, '0);
    drive('0, 32'hFFFF_FFFF, '0);
    drive('0, '0, 32'hFFFF_FFFF);
    drive(32'h0000_4000, '0, '0);
    drive('0, 32'h0100_0000, '0);
    drive('0, 32'h0010_0000, '0);
    wcfg(32'hFFFF_FFFF);
    drive(32'hFFFF_FFFF, '0, '0);
    drive('0, 32'h0003_FFFF, '0);
    drive('0, '0, 32'hFFFF_FFFF);
    drive('0, 32'h00FC_0000, '0);
    wcfg(32'hAAAA_AAAA);
    drive(32'h0000_2001, 32'h0002_0001, 32'h8000_0001);
    drive('0, '0, 32'h5555_5555);
    drive('0, '0, 32'hAAAA_AAAA);

    for (int it = 0; it < 400; it++) begin
      if ((it % 25) == 0) wcfg($urandom);
      drive($urandom & $urandom, $urandom & $urandom, $urandom & $urandom);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule